// File: doc/BRIEF.md
# Seeded Random Delay-Pair Differencer

The block turns two banks of measured path delays into a stream of signed delay differences. One bank holds delays measured on rising transitions, the other delays measured on falling transitions. For every difference, a 16-bit linear feedback shift register picks one entry from each bank. The block subtracts the falling-edge delay from the rising-edge delay and emits the result with a one-cycle valid strobe and a running index.

The register seed is the XOR of two nonces, one supplied by the verifying server and one by the device. A seed load sets the starting point. A start request with a count then produces that many differences back to back. The same seed always gives the same pairing order, so the server can recompute the pairings from the two nonces. Both banks are external memories with a one-cycle registered read. The block drives their addresses and takes their data one cycle later.

Top module: `delay_pair_diff`

## Requirements
- R1: After reset, busy_o and diff_valid_o are low, and the register holds 16'hACE1.
- R2: A seed_load_i pulse while busy_o is low loads nonce_srv_i XOR nonce_tok_i into the register. If that XOR is zero, the register is loaded with 16'hACE1 instead.
- R3: The register steps as next = {s[14:0], s[15]^s[13]^s[12]^s[10]}. It steps exactly once per difference issued, holds in every other cycle, and is never zero.
- R4: The difference issued from state s reads rise_addr_o = s[7:0] mod R_DEPTH and fall_addr_o = s[15:8] mod F_DEPTH. The first difference of a run uses the state present when the run starts.
- R5: diff_o is the rising-edge delay minus the falling-edge delay, as a DW+1 bit two's complement value.
- R6: A start_i pulse while idle, with count_i = N, produces exactly N one-cycle diff_valid_o pulses on consecutive cycles. The first pulse comes two cycles after the first address cycle. N = 0 produces nothing, and busy_o stays low.
- R7: diff_idx_o counts 0, 1, …, N-1 over the pulses of a run.
- R8: start_i and seed_load_i are ignored while busy_o is high. The running stream and its length are unchanged.
- R9: A start without a new seed load continues the register sequence where the previous run stopped. Reloading the same nonces reproduces the earlier stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nonce_srv_i | input | 16 | Server nonce |
| nonce_tok_i | input | 16 | Device nonce |
| seed_load_i | input | 1 | Load seed from the nonce XOR |
| start_i | input | 1 | Start a run |
| count_i | input | CNT_W | Number of differences in the run |
| rise_addr_o | output | clog2(R_DEPTH) | Rising-edge bank address |
| rise_data_i | input | DW | Rising-edge delay, one cycle after address |
| fall_addr_o | output | clog2(F_DEPTH) | Falling-edge bank address |
| fall_data_i | input | DW | Falling-edge delay, one cycle after address |
| busy_o | output | 1 | Run or pipeline active |
| diff_valid_o | output | 1 | Difference valid strobe |
| diff_o | output | DW+1 | Signed difference |
| diff_idx_o | output | CNT_W | Index of the difference within the run |

## Verification
The bench builds the block with R_DEPTH = 24 and F_DEPTH = 20. Neither depth is a power of two, so the modulo address reduction is exercised on every lookup. DW = 11 and CNT_W = 8 allow full 255-difference runs, which sweep a large share of both banks for several seeds. These seeds include a zero XOR, and both banks are filled with values that drive differences to both extremes of the signed range.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] SEED_FALLBACK = 16'hACE1;

  // Maximal-length polynomial x^16 + x^14 + x^13 + x^11 + 1
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/dpd_lfsr.sv
module dpd_lfsr
  import dpd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic              step_i,
  output logic [LFSR_W-1:0] state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_o <= SEED_FALLBACK;
    else if (load_i)  state_o <= (seed_i == '0) ? SEED_FALLBACK : seed_i;
    else if (step_i)  state_o <= lfsr_next(state_o);
  end
endmodule

// File: rtl/dpd_addr_map.sv
module dpd_addr_map #(
  parameter int FIELD_W = 8,
  parameter int DEPTH   = 32,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [AW-1:0]      addr_o
);
  localparam logic [FIELD_W:0] DEP = (FIELD_W+1)'(DEPTH);
  logic [FIELD_W:0] rem;

  always_comb begin
    rem    = {1'b0, field_i} % DEP;
    addr_o = rem[AW-1:0];
  end
endmodule

// File: rtl/dpd_ctrl.sv
module dpd_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             issue_o,
  output logic [CNT_W-1:0] idx_o
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issue_o <= 1'b0;
      left_q  <= '0;
      idx_o   <= '0;
    end else if (issue_o) begin
      left_q <= left_q - 1'b1;
      idx_o  <= idx_o + 1'b1;
      if (left_q == CNT_W'(1)) issue_o <= 1'b0;
    end else if (start_i && count_i != '0) begin
      issue_o <= 1'b1;
      left_q  <= count_i;
      idx_o   <= '0;
    end
  end
endmodule

// File: rtl/delay_pair_diff.sv
module delay_pair_diff
  import dpd_pkg::*;
#(
  parameter int DW      = 11,
  parameter int R_DEPTH = 32,
  parameter int F_DEPTH = 32,
  parameter int CNT_W   = 8,
  localparam int DIFF_W  = DW + 1,
  localparam int R_AW    = $clog2(R_DEPTH),
  localparam int F_AW    = $clog2(F_DEPTH),
  localparam int FIELD_W = LFSR_W / 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [LFSR_W-1:0]        nonce_srv_i,
  input  logic [LFSR_W-1:0]        nonce_tok_i,
  input  logic                     seed_load_i,
  input  logic                     start_i,
  input  logic [CNT_W-1:0]         count_i,
  output logic [R_AW-1:0]          rise_addr_o,
  input  logic [DW-1:0]            rise_data_i,
  output logic [F_AW-1:0]          fall_addr_o,
  input  logic [DW-1:0]            fall_data_i,
  output logic                     busy_o,
  output logic                     diff_valid_o,
  output logic signed [DIFF_W-1:0] diff_o,
  output logic [CNT_W-1:0]         diff_idx_o
);
  logic [LFSR_W-1:0] lfsr_q;
  logic              issue;
  logic [CNT_W-1:0]  issue_idx;
  logic              s1_v_q;
  logic [CNT_W-1:0]  s1_idx_q;
  logic signed [DIFF_W-1:0] diff_d;

  assign busy_o = issue | s1_v_q;

  dpd_lfsr u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (seed_load_i && !busy_o),
    .seed_i  (nonce_srv_i ^ nonce_tok_i),
    .step_i  (issue),
    .state_o (lfsr_q)
  );

  dpd_addr_map #(.FIELD_W(FIELD_W), .DEPTH(R_DEPTH)) u_rise_map (
    .field_i (lfsr_q[FIELD_W-1:0]),
    .addr_o  (rise_addr_o)
  );

  dpd_addr_map #(.FIELD_W(FIELD_W), .DEPTH(F_DEPTH)) u_fall_map (
    .field_i (lfsr_q[LFSR_W-1:FIELD_W]),
    .addr_o  (fall_addr_o)
  );

  dpd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i && !busy_o),
    .count_i (count_i),
    .issue_o (issue),
    .idx_o   (issue_idx)
  );

  // Memory data lands one cycle after the address cycle
  assign diff_d = $signed({1'b0, rise_data_i}) - $signed({1'b0, fall_data_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v_q       <= 1'b0;
      s1_idx_q     <= '0;
      diff_valid_o <= 1'b0;
      diff_o       <= '0;
      diff_idx_o   <= '0;
    end else begin
      s1_v_q       <= issue;
      s1_idx_q     <= issue_idx;
      diff_valid_o <= s1_v_q;
      if (s1_v_q) begin
        diff_o     <= diff_d;
        diff_idx_o <= s1_idx_q;
      end
    end
  end
endmodule

// File: rtl/delay_pair_diff_chk.sv
module dpd_checker #(
  parameter int DW      = 11,
  parameter int R_DEPTH = 32,
  parameter int F_DEPTH = 32,
  parameter int CNT_W   = 8,
  localparam int DIFF_W = DW + 1,
  localparam int R_AW   = $clog2(R_DEPTH),
  localparam int F_AW   = $clog2(F_DEPTH)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     seed_load_i,
  input logic                     busy_o,
  input logic                     issue_i,
  input logic [15:0]              lfsr_i,
  input logic [R_AW-1:0]          rise_addr_o,
  input logic [F_AW-1:0]          fall_addr_o,
  input logic                     diff_valid_o,
  input logic signed [DIFF_W-1:0] diff_o,
  input logic [CNT_W-1:0]         diff_idx_o
);
  localparam logic [DIFF_W-1:0] MIN_NEG = {1'b1, {DW{1'b0}}};

  p_lfsr_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_i != '0);

  p_lfsr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!issue_i && !(seed_load_i && !busy_o)) |=> $stable(lfsr_i));

  p_seed_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !issue_i) |=> $stable(lfsr_i));

  p_addr_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(rise_addr_o) < R_DEPTH) && (int'(fall_addr_o) < F_DEPTH));

  p_diff_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diff_valid_o |-> diff_o != MIN_NEG);

  p_valid_in_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diff_valid_o |-> $past(busy_o));

  p_idx_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (diff_valid_o && $past(diff_valid_o)) |-> diff_idx_o == $past(diff_idx_o) + 1'b1);
endmodule

bind delay_pair_diff dpd_checker #(
  .DW(DW), .R_DEPTH(R_DEPTH), .F_DEPTH(F_DEPTH), .CNT_W(CNT_W)
) u_dpd_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .seed_load_i  (seed_load_i),
  .busy_o       (busy_o),
  .issue_i      (issue),
  .lfsr_i       (lfsr_q),
  .rise_addr_o  (rise_addr_o),
  .fall_addr_o  (fall_addr_o),
  .diff_valid_o (diff_valid_o),
  .diff_o       (diff_o),
  .diff_idx_o   (diff_idx_o)
);

// File: tb/delay_pair_diff_bench.sv
module delay_pair_diff_bench;
  localparam int DW = 11;
  localparam int RD = 24;
  localparam int FD = 20;
  localparam int CW = 8;
  localparam int DIFF_W = DW + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [15:0] nonce_srv_i = '0;
  logic [15:0] nonce_tok_i = '0;
  logic seed_load_i = 1'b0;
  logic start_i = 1'b0;
  logic [CW-1:0] count_i = '0;
  logic [$clog2(RD)-1:0] rise_addr_o;
  logic [$clog2(FD)-1:0] fall_addr_o;
  logic [DW-1:0] rise_data_i = '0;
  logic [DW-1:0] fall_data_i = '0;
  logic busy_o, diff_valid_o;
  logic signed [DIFF_W-1:0] diff_o;
  logic [CW-1:0] diff_idx_o;

  always #2.5 clk = ~clk;

  delay_pair_diff #(.DW(DW), .R_DEPTH(RD), .F_DEPTH(FD), .CNT_W(CW)) u_delay_pair_diff (
    .clk_i(clk), .rst_ni(rst_ni),
    .nonce_srv_i(nonce_srv_i), .nonce_tok_i(nonce_tok_i),
    .seed_load_i(seed_load_i), .start_i(start_i), .count_i(count_i),
    .rise_addr_o(rise_addr_o), .rise_data_i(rise_data_i),
    .fall_addr_o(fall_addr_o), .fall_data_i(fall_data_i),
    .busy_o(busy_o), .diff_valid_o(diff_valid_o),
    .diff_o(diff_o), .diff_idx_o(diff_idx_o)
  );

  int rise_mem [RD];
  int fall_mem [FD];
  logic signed [DIFF_W-1:0] e_diff [256];
  logic [15:0] m_state = 16'hACE1;
  int checks = 0;
  int errors = 0;
  int got_n = 0;
  int cycles = 0;

  // Registered-read memory model
  always_ff @(posedge clk) begin
    rise_data_i <= DW'(rise_mem[rise_addr_o]);
    fall_data_i <= DW'(fall_mem[fall_addr_o]);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  always @(negedge clk) begin
    if (rst_ni) begin
      if (diff_valid_o) begin
        chk(int'(diff_idx_o) == got_n, "R7 index", int'(diff_idx_o), got_n);
        chk(diff_o == e_diff[diff_idx_o], "R5 difference", int'(diff_o), int'(e_diff[diff_idx_o]));
        got_n++;
      end
      if (busy_o)
        chk(int'(rise_addr_o) < RD && int'(fall_addr_o) < FD, "R4 address range",
            int'(rise_addr_o), int'(fall_addr_o));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic load_seed(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    nonce_srv_i = a; nonce_tok_i = b; seed_load_i = 1'b1;
    @(negedge clk);
    seed_load_i = 1'b0;
    m_state = ((a ^ b) == 16'h0) ? 16'hACE1 : (a ^ b);
  endtask

  task automatic prep(input int n);
    for (int i = 0; i < n; i++) begin
      e_diff[i] = DIFF_W'(rise_mem[m_state[7:0] % RD] - fall_mem[m_state[15:8] % FD]);
      m_state = m_next(m_state);
    end
    got_n = 0;
  endtask

  task automatic run(input int n, input bit disturb);
    prep(n);
    @(negedge clk);
    start_i = 1'b1; count_i = CW'(n);
    @(negedge clk);
    start_i = 1'b0;
    if (n == 0) chk(busy_o == 1'b0, "R6 zero count busy", int'(busy_o), 0);
    else chk(busy_o == 1'b1, "R6 busy on start", int'(busy_o), 1);
    if (disturb) begin
      // R8: seed load and start while busy must be ignored
      nonce_srv_i = 16'h5A5A; nonce_tok_i = 16'h0F0F;
      seed_load_i = 1'b1; start_i = 1'b1; count_i = CW'(3);
      @(negedge clk);
      seed_load_i = 1'b0; start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(got_n == n, disturb ? "R8 stream length" : "R6 pulse count", got_n, n);
  endtask

  initial begin
    for (int i = 0; i < RD; i++) rise_mem[i] = (i * 173 + 37) % 2048;
    for (int i = 0; i < FD; i++) fall_mem[i] = (i * 311 + 1900) % 2048;
    rise_mem[0] = 2047; fall_mem[0] = 0;
    rise_mem[1] = 0;    fall_mem[1] = 2047;

    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R1 busy in reset", int'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
    chk(diff_valid_o == 1'b0, "R1 valid after reset", int'(diff_valid_o), 0);

    // R1: reset state ACE1 used without any seed load
    run(5, 1'b0);

    // R2: zero XOR falls back to ACE1
    load_seed(16'h1357, 16'h1357);
    run(9, 1'b0);

    // R3/R4/R5: sweep over several seeds and run lengths
    for (int k = 0; k < 6; k++) begin
      load_seed(16'h1234 * 16'(k + 1), 16'hC3A5 ^ 16'(k * 977));
      run(255, 1'b0);
      run(1, 1'b0);
      run(7, 1'b0);
    end

    // R6: zero count gives nothing
    run(0, 1'b0);

    // R8: disturbance during a run
    load_seed(16'hBEEF, 16'h0001);
    run(6, 1'b1);
    run(1, 1'b1);

    // R9: continuation then exact replay after reload
    load_seed(16'h8000, 16'h0000);
    run(10, 1'b0);
    run(10, 1'b0);
    load_seed(16'h8000, 16'h0000);
    run(20, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule